// File: doc/BRIEF.md
# SENT Synchronous Trigger Pulse Generator

This block asks a synchronous SENT sensor for a frame by pulling the shared SENT line low for a set time. Up to four addressable sensors can hang on one wire. Each sensor slot has its own pulse length in ticks, and the sensors tell the requests apart by that width. A request comes from one of two places. The first is an asynchronous hardware pin, which is synchronised and edge detected. The second is a one-cycle software strobe from the control register logic. Each request carries a slot number.

The block accepts one request when it is idle. It drives the line low for the chosen slot's length, then releases the line and pulses `done_o`. It stays busy until the frame receiver reports the end of the frame that the pulse asked for. A request that comes while the block is busy is dropped and sets a sticky overrun flag. The flag clears only through a clear strobe.

Top module: `sent_trig_gen`

## Requirements
- R1: After reset, `line_low_o`, `busy_o`, `done_o` and `overrun_o` are all 0.
- R2: A software strobe taken while idle starts the pulse at the next clock edge. `line_low_o` is then 1 for exactly L*TICK_DIV clock cycles, where L is the selected slot's length and TICK_DIV defaults to 4.
- R3: The pulse length comes from the slot named by the request's select field. Slot i's length sits in bits [i*LEN_W +: LEN_W] of `slot_len_i`. `active_sel_o` shows that slot and holds steady while busy.
- R4: A rising edge on `hw_trig_i` gives exactly one pulse. Holding the pin high gives no further pulse.
- R5: `busy_o` goes to 1 in the cycle the pulse starts. It stays 1 through the pulse and through the wait for end of frame, and drops in the cycle after `frame_end_i` is seen in the wait phase.
- R6: `done_o` is a one-cycle pulse in the first cycle that `line_low_o` is back at 0 after a pulse.
- R7: A request while busy is ignored. The running pulse and any later pulse are unaffected, and `overrun_o` goes to 1 and stays there until `ovr_clr_i` is strobed. A new overrun event wins over a clear in the same cycle.
- R8: When a hardware edge and a software strobe are both seen while idle, the hardware request is served and the software request counts as an overrun.
- R9: A slot length of 0 is treated as one tick (TICK_DIV cycles).
- R10: `frame_end_i` has no effect while the block is idle or while the pulse is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig_i | input | 1 | Asynchronous hardware trigger pin; rising edge requests a pulse |
| hw_sel_i | input | SEL_W | Slot number for hardware requests |
| sw_trig_i | input | 1 | One-cycle software trigger strobe |
| sw_sel_i | input | SEL_W | Slot number for software requests |
| slot_len_i | input | NUM_SLOTS*LEN_W | Per-slot pulse lengths in ticks |
| frame_end_i | input | 1 | Receiver reports end of the requested frame |
| ovr_clr_i | input | 1 | Clears the sticky overrun flag |
| line_low_o | output | 1 | Open-drain enable: 1 pulls the SENT line low |
| busy_o | output | 1 | Pulse or frame wait in progress |
| done_o | output | 1 | One-cycle strobe when the pulse ends |
| active_sel_o | output | SEL_W | Slot of the current or last pulse |
| overrun_o | output | 1 | Sticky flag for dropped requests |

## Verification
Several rules are checked on every clock cycle:
- the line is never pulled low unless the block is busy;
- a pulse starts in the same cycle that busy rises;
- done lasts one cycle and comes exactly at line release;
- the overrun flag holds until cleared;
- the active slot holds steady while busy.

Some behaviour can only be shown by bench scenarios that compare against computed values. This covers the exact pulse width for each slot length, including zero, and the one-pulse-per-edge behaviour of the hardware pin. It also covers hardware winning over a simultaneous software request, and end-of-frame being ignored during a pulse.

// File: rtl/sent_trig_pkg.sv
package sent_trig_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PULSE = 2'd1,
      ST_WAIT  = 2'd2
   } trig_state_e;

   function automatic int unsigned sel_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sent_trig_edge.sv
// Synchroniser plus rising-edge detector for the hardware trigger pin.
module sent_trig_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sent_trig_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/sent_trig_arb.sv
// Chooses between hardware and software requests and looks up the slot length.
module sent_trig_arb #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned LEN_W     = 12,
   parameter int unsigned SEL_W     = 2
) (
   input  logic                       hw_rise_i,
   input  logic [SEL_W-1:0]           hw_sel_i,
   input  logic                       sw_req_i,
   input  logic [SEL_W-1:0]           sw_sel_i,
   input  logic [NUM_SLOTS*LEN_W-1:0] slot_len_i,
   output logic                       req_o,
   output logic [SEL_W-1:0]           req_sel_o,
   output logic [LEN_W-1:0]           req_len_o,
   output logic                       loser_o
);

   logic [LEN_W-1:0] len_a [NUM_SLOTS];
   logic [LEN_W-1:0] raw_len;
   logic             hw_ok;
   logic             sw_ok;

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_unpack
         assign len_a[i] = slot_len_i[i*LEN_W +: LEN_W];
      end
   endgenerate

   always_comb begin
      hw_ok     = hw_rise_i && (int'(hw_sel_i) < NUM_SLOTS);
      sw_ok     = sw_req_i  && (int'(sw_sel_i) < NUM_SLOTS);
      req_o     = hw_ok | sw_ok;
      loser_o   = hw_ok & sw_ok;
      req_sel_o = hw_ok ? hw_sel_i : sw_sel_i;
      raw_len   = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (req_sel_o == SEL_W'(i)) raw_len = len_a[i];
      end
      req_len_o = (raw_len == '0) ? LEN_W'(1) : raw_len;
   end

endmodule

// File: rtl/sent_trig_timer.sv
// Counts the pulse length as a number of ticks of TICK_DIV clocks each.
module sent_trig_timer #(
   parameter int unsigned LEN_W    = 12,
   parameter int unsigned TICK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             run_i,
   output logic             last_o
);

   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] tick_cnt_q;
   logic             tick;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("sent_trig_timer: TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = run_i;
      end else begin : g_div
         localparam int unsigned DIV_W = $clog2(TICK_DIV);
         localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (start_i) begin
               div_q <= '0;
            end else if (run_i) begin
               div_q <= (div_q == DIV_TOP) ? '0 : div_q + 1'b1;
            end
         end
         assign tick = run_i && (div_q == DIV_TOP);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q      <= LEN_W'(1);
         tick_cnt_q <= '0;
      end else if (start_i) begin
         len_q      <= len_i;
         tick_cnt_q <= '0;
      end else if (tick) begin
         tick_cnt_q <= tick_cnt_q + 1'b1;
      end
   end

   assign last_o = tick && (tick_cnt_q == len_q - LEN_W'(1));

endmodule

// File: rtl/sent_trig_gen.sv
module sent_trig_gen
   import sent_trig_pkg::*;
#(
   parameter int unsigned NUM_SLOTS   = 4,
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned TICK_DIV    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = sel_width(NUM_SLOTS),
   localparam int unsigned LENS_W     = NUM_SLOTS * LEN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_trig_i,
   input  logic [SEL_W-1:0]  hw_sel_i,
   input  logic              sw_trig_i,
   input  logic [SEL_W-1:0]  sw_sel_i,
   input  logic [LENS_W-1:0] slot_len_i,
   input  logic              frame_end_i,
   input  logic              ovr_clr_i,
   output logic              line_low_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [SEL_W-1:0]  active_sel_o,
   output logic              overrun_o
);

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
         $error("sent_trig_gen: NUM_SLOTS must be 1 to 4");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("sent_trig_gen: LEN_W must be at least 1");
      end
   endgenerate

   trig_state_e      state_q;
   logic             hw_rise;
   logic             req;
   logic             loser;
   logic [SEL_W-1:0] req_sel;
   logic [LEN_W-1:0] req_len;
   logic             accept;
   logic             in_pulse;
   logic             last;
   logic             drive_q;
   logic             done_q;
   logic             ovr_q;
   logic             ovr_set;
   logic [SEL_W-1:0] sel_q;

   sent_trig_edge #(.STAGES(SYNC_STAGES)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (hw_trig_i),
      .rise_o (hw_rise)
   );

   sent_trig_arb #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W), .SEL_W(SEL_W)) arb_i (
      .hw_rise_i  (hw_rise),
      .hw_sel_i   (hw_sel_i),
      .sw_req_i   (sw_trig_i),
      .sw_sel_i   (sw_sel_i),
      .slot_len_i (slot_len_i),
      .req_o      (req),
      .req_sel_o  (req_sel),
      .req_len_o  (req_len),
      .loser_o    (loser)
   );

   assign accept   = req && (state_q == ST_IDLE);
   assign in_pulse = (state_q == ST_PULSE);

   sent_trig_timer #(.LEN_W(LEN_W), .TICK_DIV(TICK_DIV)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .len_i   (req_len),
      .run_i   (in_pulse),
      .last_o  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         drive_q <= 1'b0;
         sel_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_PULSE;
                  drive_q <= 1'b1;
                  sel_q   <= req_sel;
               end
            end
            ST_PULSE: begin
               if (last) begin
                  state_q <= ST_WAIT;
                  drive_q <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (frame_end_i) state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
               drive_q <= 1'b0;
            end
         endcase
      end
   end

   assign ovr_set = (req && (state_q != ST_IDLE)) || loser;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         done_q <= in_pulse && last;
         ovr_q  <= (ovr_q && !ovr_clr_i) || ovr_set;
      end
   end

   assign line_low_o   = drive_q;
   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = done_q;
   assign active_sel_o = sel_q;
   assign overrun_o    = ovr_q;

endmodule

// File: rtl/sent_trig_chk.sv
module sent_trig_chk #(
   parameter int unsigned SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_low,
   input logic             busy,
   input logic             done,
   input logic             ovr,
   input logic             ovr_clr,
   input logic [SEL_W-1:0] sel
);

   AST_DRIVE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      line_low |-> busy);  // R5

   AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> line_low);  // R2

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R6

   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!line_low && $past(line_low)));  // R6

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);  // R7

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sel));  // R3

endmodule

bind sent_trig_gen sent_trig_chk #(.SEL_W(SEL_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .line_low (line_low_o),
   .busy     (busy_o),
   .done     (done_o),
   .ovr      (overrun_o),
   .ovr_clr  (ovr_clr_i),
   .sel      (active_sel_o)
);

// File: tb/sent_trig_gen_tb.sv
`timescale 1ns/1ps
module sent_trig_gen_tb_top;

   localparam int NS = 4;
   localparam int LW = 12;
   localparam int TD = 4;
   localparam int SW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            hw_trig = 1'b0;
   logic [SW-1:0]   hw_sel = '0;
   logic            sw_trig = 1'b0;
   logic [SW-1:0]   sw_sel = '0;
   logic [NS*LW-1:0] slot_len;
   logic            frame_end = 1'b0;
   logic            ovr_clr = 1'b0;
   logic            line_low;
   logic            busy;
   logic            done;
   logic [SW-1:0]   act_sel;
   logic            overrun;

   int lens [NS];
   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NS; i++) slot_len[i*LW +: LW] = LW'(lens[i]);
   end

   sent_trig_gen #(.NUM_SLOTS(NS), .LEN_W(LW), .TICK_DIV(TD)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .hw_trig_i    (hw_trig),
      .hw_sel_i     (hw_sel),
      .sw_trig_i    (sw_trig),
      .sw_sel_i     (sw_sel),
      .slot_len_i   (slot_len),
      .frame_end_i  (frame_end),
      .ovr_clr_i    (ovr_clr),
      .line_low_o   (line_low),
      .busy_o       (busy),
      .done_o       (done),
      .active_sel_o (act_sel),
      .overrun_o    (overrun)
   );

   function automatic int exp_width(int len);
      return ((len == 0) ? 1 : len) * TD;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts cycles of line_low from the current negedge (line already low).
   task automatic measure(output int cnt, input bit inj_ovr, input int ovr_sel,
                          input bit inj_fe);
      cnt = 0;
      while (line_low && cnt < 2000) begin
         cnt++;
         if (cnt == 2) begin
            if (inj_ovr) begin sw_trig = 1'b1; sw_sel = SW'(ovr_sel); end
            if (inj_fe) frame_end = 1'b1;
         end
         if (cnt == 3) begin sw_trig = 1'b0; frame_end = 1'b0; end
         @(negedge clk);
      end
      sw_trig = 1'b0;
      frame_end = 1'b0;
   endtask

   task automatic finish_frame();
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      chk(busy == 1'b0, "R5 busy after frame end", busy, 0);
   endtask

   task automatic run_trigger(bit use_hw, int sel, bit inj_ovr, bit inj_fe);
      int w;
      int cnt;
      int gap;
      @(negedge clk);
      if (use_hw) begin
         hw_sel = SW'(sel);
         hw_trig = 1'b1;
         @(negedge clk);
      end else begin
         sw_sel = SW'(sel);
         sw_trig = 1'b1;
         @(negedge clk);
         sw_trig = 1'b0;
      end
      w = 0;
      while (!line_low && w < 20) begin @(negedge clk); w++; end
      chk(line_low == 1'b1, "R2 pulse started", line_low, 1);
      chk(busy == 1'b1, "R5 busy with pulse", busy, 1);
      chk(act_sel == SW'(sel), "R3 active slot", act_sel, sel);
      measure(cnt, inj_ovr, (sel + 1) % NS, inj_fe);
      chk(cnt == exp_width(lens[sel]), use_hw ? "R4 hw pulse width" : "R2 pulse width",
          cnt, exp_width(lens[sel]));
      chk(done == 1'b1, "R6 done at release", done, 1);
      chk(busy == 1'b1, "R10 still waiting for frame", busy, 1);
      if (inj_ovr) chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
      gap = $urandom_range(0, 3);
      for (int i = 0; i < gap; i++) @(negedge clk);
      chk(line_low == 1'b0 && busy == 1'b1, "R5 wait phase", {line_low, busy}, 1);
      finish_frame();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (line_low) break;
      end
      chk(line_low == 1'b0, use_hw ? "R4 no repeat pulse" : "R7 no queued pulse", line_low, 0);
      hw_trig = 1'b0;
      if (inj_ovr) begin
         ovr_clr = 1'b1;
         @(negedge clk);
         ovr_clr = 1'b0;
         chk(overrun == 1'b0, "R7 overrun cleared", overrun, 0);
      end
      for (int i = 0; i < 4; i++) @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int cnt;
      void'($urandom(32'd4711));
      for (int i = 0; i < NS; i++) lens[i] = i + 2;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(line_low == 1'b0, "R1 line released", line_low, 0);
      chk(busy == 1'b0, "R1 not busy", busy, 0);
      chk(done == 1'b0, "R1 no done", done, 0);
      chk(overrun == 1'b0, "R1 no overrun", overrun, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: frame end while idle does nothing
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0 && line_low == 1'b0, "R10 idle frame end", busy, 0);

      // Directed: every slot via software, then via hardware
      for (int s = 0; s < NS; s++) run_trigger(1'b0, s, 1'b0, 1'b0);
      for (int s = 0; s < NS; s++) run_trigger(1'b1, s, 1'b0, 1'b0);

      // R9: zero length slot
      lens[2] = 0;
      run_trigger(1'b0, 2, 1'b0, 1'b0);
      lens[2] = 4;

      // R7 and R10 during a pulse
      run_trigger(1'b0, 3, 1'b1, 1'b1);

      // R8: hardware edge and software strobe seen together
      lens[1] = 3;
      lens[2] = 7;
      @(negedge clk);
      hw_sel = 2'd1;
      hw_trig = 1'b1;
      @(negedge clk);
      @(negedge clk);
      sw_sel = 2'd2;
      sw_trig = 1'b1;
      @(negedge clk);
      sw_trig = 1'b0;
      chk(line_low == 1'b1, "R8 pulse started", line_low, 1);
      chk(act_sel == 2'd1, "R8 hw slot wins", act_sel, 1);
      chk(overrun == 1'b1, "R8 sw counted as overrun", overrun, 1);
      measure(cnt, 1'b0, 0, 1'b0);
      chk(cnt == exp_width(3), "R8 hw slot width", cnt, exp_width(3));
      finish_frame();
      hw_trig = 1'b0;
      ovr_clr = 1'b1;
      @(negedge clk);
      ovr_clr = 1'b0;
      chk(overrun == 1'b0, "R7 clear after R8", overrun, 0);

      // Constrained random trials
      for (int t = 0; t < 40; t++) begin
         for (int i = 0; i < NS; i++) lens[i] = $urandom_range(0, 15);
         run_trigger(1'($urandom_range(0, 1)), $urandom_range(0, NS - 1),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule